// File: doc/BRIEF.md
# Dual-Channel Serial ADC Read Controller

This block is the host-side master for a two-channel successive-approximation converter that is reached over a three-wire serial link: an active-low chip select, a serial clock and a pair of data lines. A request names one of the two channels. The controller then drops chip select once, which is the sampling instant. It runs the serial clock from the system clock through a divider, places the channel-select bit on the host-to-converter line and shifts in the reply from the converter-to-host line.

The reply frame starts with a zero bit. A channel-tag bit follows, then the sample in plain binary, most significant bit first. After the last serial clock the controller raises chip select and presents the sample right-aligned on a 12-bit bus with a one-cycle strobe. It also flags a reply whose channel tag differs from the request. A quiet gap with chip select high is enforced before another request can start a frame. The frame length follows the chosen resolution: 16 clocks for 12 bits and 14 clocks for 10 bits.

Top module: `adc_dual_ch_reader`

## Requirements
- R1: While reset is high and after it falls, until a request arrives, cs_n and sclk are 1, din, busy and smp_valid are 0.
- R2: A start seen while busy is 0 drives cs_n low and busy high one cycle later. cs_n falls exactly once per accepted request.
- R3: The first sclk falling edge comes HALF_CYC cycles after cs_n falls. Later falling edges follow every 2*HALF_CYC cycles, giving a 50% duty serial clock, and sclk never falls while cs_n is high.
- R4: A frame has 16 sclk falling edges when res12 was 1 at the request and 14 when it was 0. cs_n rises together with the sclk rise that follows the last falling edge, 2*HALF_CYC*edges cycles after cs_n fell.
- R5: din carries the requested channel (1 selects channel 1) from the sclk rise after the first falling edge until the sclk rise after the second falling edge. At all other times din is 0, so the converter reads the channel on the second falling edge.
- R6: dout is captured at every sclk falling edge, as the value present just before the edge. Capture k (0-based) holds reply bit k: bit 0 is the zero, bit 1 the channel tag, then the sample MSB first. smp_data holds the sample right-aligned, with bits 11:10 zero in 10-bit mode.
- R7: smp_valid is high for exactly one cycle, the cycle in which cs_n rises. smp_data, smp_ch and ch_mismatch keep their values until the next strobe.
- R8: smp_ch is the received tag bit, and ch_mismatch is 1 exactly when the tag differs from the requested channel.
- R9: busy stays high from the cs_n fall until QUIET_CYC cycles after the cs_n rise, and cs_n stays high for that whole gap.
- R10: A start raised while busy is 1 has no effect: the running frame's din, timing and result are unchanged, and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a conversion (taken only when idle) |
| start_ch | input | 1 | Channel to convert, 0 or 1 |
| res12 | input | 1 | 1 selects a 12-bit frame, 0 a 10-bit frame |
| dout | input | 1 | Serial reply from the converter |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock, idles high |
| din | output | 1 | Channel-select line to the converter |
| busy | output | 1 | Frame or quiet gap in progress |
| smp_valid | output | 1 | One-cycle result strobe |
| smp_data | output | 12 | Received sample, right-aligned |
| smp_ch | output | 1 | Channel tag from the reply |
| ch_mismatch | output | 1 | Tag differs from the requested channel |

## Verification
Every result is tied to the cycle in which chip select falls, one cycle after the accepted request. The first serial-clock fall is due HALF_CYC cycles later and each further fall 2*HALF_CYC cycles after the one before. The strobe and the chip-select rise are due 2*HALF_CYC times the edge count after the fall, and busy drops QUIET_CYC cycles after that. The bench counts cycles from the observed chip-select fall and samples on the falling system-clock edge, then compares each event's cycle with these sums. A converter model in the bench supplies random samples and tags, and the bench raises stray requests during frames to show they leave the frame untouched.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int FRAME_MAX = 16;
  localparam int SMP_W     = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_GAP
  } rd_state_t;

  // number of serial-clock falling edges in one frame
  function automatic logic [4:0] frame_edges(input logic wide);
    return wide ? 5'd16 : 5'd14;
  endfunction

  // sample field of the captured frame, right-aligned
  // capture k sits at bit (edges-1-k); the sample starts at capture 2
  function automatic logic [SMP_W-1:0] pick_sample(input logic [FRAME_MAX-1:0] sr,
                                                   input logic wide);
    return wide ? sr[13:2] : {2'b00, sr[11:2]};
  endfunction

  // channel tag, capture 1 of the frame
  function automatic logic pick_tag(input logic [FRAME_MAX-1:0] sr, input logic wide);
    return wide ? sr[14] : sr[12];
  endfunction

endpackage

// File: rtl/adc_rd_halfdiv.sv
module adc_rd_halfdiv #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_rd_rxshift.sv
module adc_rd_rxshift #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic             bit_in,
  output logic [DEPTH-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst || clr) sr <= '0;
    else if (shift) sr <= {sr[DEPTH-2:0], bit_in};
  end
endmodule

// File: rtl/adc_rd_gap.sv
module adc_rd_gap #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_dual_ch_reader.sv
module adc_dual_ch_reader
  import adc_rd_pkg::*;
#(
  parameter int HALF_CYC  = 5,
  parameter int QUIET_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_ch,
  input  logic              res12,
  input  logic              dout,
  output logic              cs_n,
  output logic              sclk,
  output logic              din,
  output logic              busy,
  output logic              smp_valid,
  output logic [SMP_W-1:0]  smp_data,
  output logic              smp_ch,
  output logic              ch_mismatch
);

  rd_state_t            st;
  logic                 ch_q;
  logic                 r12_q;
  logic [4:0]           edge_cnt;
  logic [FRAME_MAX-1:0] rx_sr;

  // named events
  logic tick;
  logic gap_done;
  logic start_acc;
  logic fall_evt;
  logic rise_evt;
  logic frame_end;
  logic [4:0] n_edges;

  assign n_edges   = frame_edges(r12_q);
  assign start_acc = (st == ST_IDLE) && start;
  assign fall_evt  = tick && ((st == ST_SETUP) || ((st == ST_SHIFT) && sclk));
  assign rise_evt  = tick && (st == ST_SHIFT) && !sclk;
  assign frame_end = rise_evt && (edge_cnt == n_edges);

  adc_rd_halfdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  ((st == ST_SETUP) || (st == ST_SHIFT)),
    .tick (tick)
  );

  adc_rd_rxshift #(.DEPTH(FRAME_MAX)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clr    (start_acc),
    .shift  (fall_evt),
    .bit_in (dout),
    .sr     (rx_sr)
  );

  adc_rd_gap #(.GAP_CYC(QUIET_CYC)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .run  (st == ST_GAP),
    .done (gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cs_n        <= 1'b1;
      sclk        <= 1'b1;
      din         <= 1'b0;
      busy        <= 1'b0;
      smp_valid   <= 1'b0;
      smp_data    <= '0;
      smp_ch      <= 1'b0;
      ch_mismatch <= 1'b0;
      ch_q        <= 1'b0;
      r12_q       <= 1'b0;
      edge_cnt    <= '0;
    end else begin
      smp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_acc) begin
            st       <= ST_SETUP;
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            ch_q     <= start_ch;
            r12_q    <= res12;
            edge_cnt <= '0;
          end
        end
        ST_SETUP: begin
          if (fall_evt) begin
            sclk     <= 1'b0;
            edge_cnt <= 5'd1;
            st       <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (rise_evt) begin
            sclk <= 1'b1;
            din  <= (edge_cnt == 5'd1) ? ch_q : 1'b0;
            if (frame_end) begin
              cs_n        <= 1'b1;
              smp_valid   <= 1'b1;
              smp_data    <= pick_sample(rx_sr, r12_q);
              smp_ch      <= pick_tag(rx_sr, r12_q);
              ch_mismatch <= pick_tag(rx_sr, r12_q) != ch_q;
              st          <= ST_GAP;
            end
          end else if (fall_evt) begin
            sclk     <= 1'b0;
            edge_cnt <= edge_cnt + 5'd1;
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            busy <= 1'b0;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        sclk,
  input logic        din,
  input logic        busy,
  input logic        smp_valid,
  input logic [11:0] smp_data,
  input logic        ch_q,
  input logic        r12_q
);

  // R1: idle levels whenever no frame or gap is running
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && sclk && !din && !smp_valid));

  // R2: chip select only low while busy
  assert_cs_within_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R3: serial clock only falls inside a frame
  assert_sclk_fall_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> !cs_n);

  // R5: din low whenever the frame is not running
  assert_din_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !din);

  // R6: 10-bit results keep upper bits clear
  assert_narrow_result_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !r12_q) |-> (smp_data[11:10] == 2'b00));

  // R7: strobe lands on the chip-select rise and lasts one cycle
  assert_valid_on_cs_rise_R7: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (cs_n && !$past(cs_n)));
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  // R9: busy drops only after chip select has been high
  assert_busy_drop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cs_n && $past(cs_n)));

  // R10: request captured at acceptance is held while busy
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(ch_q) && $stable(r12_q)));

endmodule

bind adc_dual_ch_reader adc_rd_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .din       (din),
  .busy      (busy),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .ch_q      (ch_q),
  .r12_q     (r12_q)
);

// File: tb/test_adc_dual_ch_reader.sv
`timescale 1ns/1ps
module test_adc_dual_ch_reader;

  localparam int H = 5;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, start_ch = 1'b0, res12 = 1'b0;
  logic dout_m = 1'b0;
  logic cs_n, sclk, din, busy, smp_valid, smp_ch, ch_mismatch;
  logic [11:0] smp_data;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_dual_ch_reader #(.HALF_CYC(H), .QUIET_CYC(Q)) i_adc_dual_ch_reader (
    .clk(clk), .rst(rst), .start(start), .start_ch(start_ch), .res12(res12),
    .dout(dout_m), .cs_n(cs_n), .sclk(sclk), .din(din), .busy(busy),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ch(smp_ch),
    .ch_mismatch(ch_mismatch)
  );

  // converter model
  logic [15:0] m_frame = '0;
  int          m_nb = 16;
  int          m_idx = 0;
  logic        m_din_seen = 1'b0;

  always @(negedge cs_n) begin
    m_idx  = 0;
    dout_m = m_frame[15];
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      m_idx = m_idx + 1;
      if (m_idx == 2) m_din_seen = din;
      dout_m = (m_idx < m_nb) ? m_frame[15 - m_idx] : 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int edges_of(input bit w);
    return w ? 16 : 14;
  endfunction

  function automatic int expect_data(input bit w, input logic [11:0] v);
    return w ? int'(v) : int'(v & 12'h3FF);
  endfunction

  task automatic run_frame(input bit ch, input bit w, input logic [11:0] v,
                           input bit flip, input bit noisy);
    int k = 0, nfall = 0, nrise = 0, first_k = -1, last_k = 0, gap_err = 0;
    int din_err = 0, vcount = 0, valid_k = -1, rise_k = -1, busy_k = -1, extra = 0;
    int n = edges_of(w);
    logic prev_s = 1'b1, prev_c = 1'b0;
    logic [11:0] got_d = '0;
    logic got_ch = 1'b0, got_mis = 1'b0;
    bit cs_idle = 1'b1;
    logic tag = ch ^ flip;
    m_nb    = n;
    m_frame = w ? {1'b0, tag, v, 2'b00} : {1'b0, tag, v[9:0], 4'b0000};
    @(negedge clk);
    start = 1'b1; start_ch = ch; res12 = w;
    @(negedge clk);
    start = 1'b0; start_ch = ~ch; res12 = ~w;
    chk(!cs_n && busy, "R2 cs_n low one cycle after start", int'(cs_n), 0);
    while (k < 2000) begin
      @(negedge clk);
      k++;
      if (prev_s && !sclk) begin
        nfall++;
        if (nfall == 1) first_k = k;
        else if (k - last_k != 2 * H) gap_err++;
        last_k = k;
      end
      if (!prev_s && sclk) nrise++;
      if (din !== ((!cs_n && nrise == 1) ? ch : 1'b0)) din_err++;
      if (smp_valid) begin
        vcount++; valid_k = k; got_d = smp_data; got_ch = smp_ch; got_mis = ch_mismatch;
      end
      if (cs_n && !prev_c && rise_k < 0) rise_k = k;
      if (prev_c && !cs_n) extra++;
      prev_s = sclk; prev_c = cs_n;
      if (!busy) begin
        busy_k = k; start = 1'b0;
        break;
      end
      start = noisy ? 1'($urandom % 2) : 1'b0;
    end
    repeat (3) begin
      @(negedge clk);
      if (!cs_n || busy) cs_idle = 1'b0;
    end
    chk(extra == 0 && cs_idle, "R2/R10 single cs_n fall, nothing queued", extra, 0);
    chk(first_k == H, "R3 first sclk fall delay", first_k, H);
    chk(gap_err == 0, "R3 sclk fall spacing", gap_err, 0);
    chk(nfall == n, "R4 falling edge count", nfall, n);
    chk(rise_k == 2 * H * n, "R4 cs_n rise cycle", rise_k, 2 * H * n);
    chk(din_err == 0, "R5 din window", din_err, 0);
    chk(m_din_seen == ch, "R5 channel seen on second fall", int'(m_din_seen), int'(ch));
    chk(int'(got_d) == expect_data(w, v), "R6 sample value", int'(got_d), expect_data(w, v));
    chk(vcount == 1 && valid_k == rise_k, "R7 strobe once at cs_n rise", valid_k, rise_k);
    chk(int'(smp_data) == expect_data(w, v), "R7 sample held", int'(smp_data), expect_data(w, v));
    chk(got_ch == tag && got_mis == flip, "R8 tag and mismatch", int'(got_mis), int'(flip));
    chk(busy_k == 2 * H * n + Q, "R9 busy fall cycle", busy_k, 2 * H * n + Q);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !din && !busy && !smp_valid, "R1 levels in reset", int'(busy), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(cs_n && sclk && !din && !busy && !smp_valid, "R1 levels after reset", int'(cs_n), 1);
    // directed corners
    run_frame(1'b0, 1'b1, 12'h000, 1'b0, 1'b0);
    run_frame(1'b1, 1'b1, 12'hFFF, 1'b0, 1'b0);
    run_frame(1'b1, 1'b0, 12'hFFF, 1'b0, 1'b0);
    run_frame(1'b0, 1'b0, 12'h2AA, 1'b1, 1'b0);
    run_frame(1'b1, 1'b1, 12'hA5A, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 60; i++)
      run_frame(1'($urandom % 2), 1'($urandom % 2), 12'($urandom),
                1'(($urandom % 4) == 0), 1'($urandom % 2));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule